// File: doc/BRIEF.md
# Memory Block Copy and Search Engine

This block is a sequencer that walks a byte-wide memory on its own once it has been given one command. Before the command it holds three 16-bit registers: a source pointer, a destination pointer and a byte counter. A command picks one of two operations. In copy mode, each byte is moved from the source address to the destination address. In search mode, each source byte is compared with an 8-bit key.

The command also picks the direction in which the pointers move, up or down. It also picks the length of the run. A single-step command handles one byte. A repeating command keeps going until the counter runs out. In search mode, a repeating command also stops early on the first byte that equals the key.

The engine talks to a plain synchronous memory. Read data appears one clock after the address. At the end of each command the engine raises a one-cycle done pulse. It then holds three results until the next command starts: a match flag, a counter-nonzero flag, and the final pointer and counter values.

Top module: `blkxfer_engine`

## Requirements
- R1: After reset, busy, done, match, cnt_nz and mem_we are all 0.
- R2: A copy byte takes exactly two cycles. In the first, the source pointer is on mem_addr and mem_we is 0. In the second, mem_we is 1, mem_addr is the destination pointer and mem_wdata is the byte read from the source. The byte-by-byte order makes overlapping regions behave as sequential moves.
- R3: With cmd_down=0, each byte adds 1 to the pointers in use and subtracts 1 from the counter.
- R4: With cmd_down=1, each byte subtracts 1 from the pointers in use and subtracts 1 from the counter.
- R5: A repeating copy (cmd_repeat=1) ends only when the counter reaches 0.
- R6: A search byte reads at the source pointer, compares it with acc_val, and steps only the source pointer. The destination pointer is left unchanged and mem_we stays 0.
- R7: A repeating search ends when the counter reaches 0 or when a byte equals acc_val, whichever comes first. match is 1 exactly when the last byte compared was equal, and it is always 0 after a copy.
- R8: A single-step command (cmd_repeat=0) handles one byte. done is a one-cycle pulse, seen 2n+1 cycles after the command cycle for n bytes.
- R9: A starting count of 0 stands for 65536 bytes. The counter wraps to 0xFFFF after the first byte and the run goes on.
- R10: cnt_nz is 1 when the counter is nonzero after the last byte. match, cnt_nz and the pointer and counter outputs hold their values from done until the next command.
- R11: cmd_valid is ignored while busy is 1.
- R12: The pointers wrap modulo 65536 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a command (accepted only when idle) |
| cmd_search | input | 1 | 1 = search, 0 = copy |
| cmd_down | input | 1 | 1 = pointers decrement, 0 = increment |
| cmd_repeat | input | 1 | 1 = repeat, 0 = single byte |
| src_init | input | 16 | Starting source pointer |
| dst_init | input | 16 | Starting destination pointer |
| cnt_init | input | 16 | Starting byte count (0 means 65536) |
| acc_val | input | 8 | Search key |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| match | output | 1 | Last compared byte equalled the key |
| cnt_nz | output | 1 | Counter nonzero at end of command |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| cnt_val | output | 16 | Current byte counter |

## Verification
Some properties are checked by assertions on every cycle:
- every write comes straight after a read cycle and is never followed by another write;
- done lasts one cycle;
- the latched command does not change while busy;
- the results stay still while idle;
- a repeating run that ends without a match has a counter of zero;
- match never comes from a copy.

Other behaviour only the bench scenarios can show, because it needs a reference memory:
- the data actually moved, including overlapping moves;
- the final pointer values under wrap in both directions;
- where a search stops;
- the 65536 meaning of a zero count;
- the exact cycle count per byte.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EVAL = 2'd2
  } bx_state_e;

  typedef struct packed {
    logic search;
    logic down;
    logic rpt;
  } bx_cmd_t;

endpackage

// File: rtl/blkxfer_step_reg.sv
// Loadable register that steps by one in either direction, wrapping modulo 2^W.
module blkxfer_step_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         down,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] q_r;
  logic [W-1:0] nxt;

  assign nxt = down ? (q_r - ONE) : (q_r + ONE);

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (load) q_r <= load_val;
    else if (step) q_r <= nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/blkxfer_cmp.sv
// Holds the search key for the duration of a command and compares it to read data.
module blkxfer_cmp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] key_in,
  input  logic [DW-1:0] rdata,
  output logic          eq
);
  logic [DW-1:0] key_q;

  always_ff @(posedge clk) begin
    if (rst)       key_q <= '0;
    else if (load) key_q <= key_in;
  end

  assign eq = (rdata == key_q);
endmodule

// File: rtl/blkxfer_seq.sv
// Per-byte sequencer: READ presents the source address, EVAL consumes the data.
module blkxfer_seq
  import blkxfer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_valid,
  input  bx_cmd_t cmd_in,
  input  logic    eq,
  input  logic    cnt_last,
  output logic    load,
  output logic    step_src,
  output logic    step_dst,
  output logic    step_cnt,
  output logic    sel_dst,
  output logic    mem_we,
  output logic    busy,
  output logic    done,
  output logic    match,
  output logic    cnt_nz,
  output bx_cmd_t cmd_q
);
  bx_state_e st_q, st_d;
  logic      stop;
  logic      done_q, match_q, nz_q;
  bx_cmd_t   cmd_r;

  always_comb begin
    st_d     = st_q;
    load     = 1'b0;
    step_src = 1'b0;
    step_dst = 1'b0;
    step_cnt = 1'b0;
    sel_dst  = 1'b0;
    mem_we   = 1'b0;
    stop     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          load = 1'b1;
          st_d = ST_READ;
        end
      end
      ST_READ: st_d = ST_EVAL;
      ST_EVAL: begin
        step_src = 1'b1;
        step_cnt = 1'b1;
        step_dst = !cmd_r.search;
        sel_dst  = !cmd_r.search;
        mem_we   = !cmd_r.search;
        stop     = !cmd_r.rpt || cnt_last || (cmd_r.search && eq);
        st_d     = stop ? ST_IDLE : ST_READ;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cmd_r   <= '0;
      done_q  <= 1'b0;
      match_q <= 1'b0;
      nz_q    <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_EVAL) && stop;
      if (load) begin
        cmd_r   <= cmd_in;
        match_q <= 1'b0;
        nz_q    <= 1'b0;
      end else if (st_q == ST_EVAL) begin
        match_q <= cmd_r.search && eq;
        nz_q    <= !cnt_last;
      end
    end
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign match  = match_q;
  assign cnt_nz = nz_q;
  assign cmd_q  = cmd_r;

  // R2
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ($past(st_q) == ST_READ));

  // R2
  no_back_to_back_wr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> $stable(cmd_r));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_valid) |=> ($stable(match_q) && $stable(nz_q)));
endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
  import blkxfer_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_search,
  input  logic          cmd_down,
  input  logic          cmd_repeat,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [CW-1:0] cnt_init,
  input  logic [DW-1:0] acc_val,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          match,
  output logic          cnt_nz,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] cnt_val
);
  localparam int            NPTR    = 2;
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  bx_cmd_t       cmd_in, cmd_q;
  logic          load, step_src, step_dst, step_cnt, sel_dst;
  logic          eq, cnt_last;
  logic [AW-1:0] ptr_init [NPTR];
  logic [AW-1:0] ptr_q    [NPTR];
  logic          ptr_step [NPTR];
  logic [CW-1:0] cnt_q;

  assign cmd_in   = '{search: cmd_search, down: cmd_down, rpt: cmd_repeat};
  assign ptr_init[0] = src_init;
  assign ptr_init[1] = dst_init;
  assign ptr_step[0] = step_src;
  assign ptr_step[1] = step_dst;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    blkxfer_step_reg #(.W(AW)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (ptr_init[g]),
      .step     (ptr_step[g]),
      .down     (cmd_q.down),
      .q        (ptr_q[g])
    );
  end

  blkxfer_step_reg #(.W(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (cnt_init),
    .step     (step_cnt),
    .down     (1'b1),
    .q        (cnt_q)
  );

  // The counter reaches zero after this byte when it currently holds one.
  assign cnt_last = (cnt_q == CNT_ONE);

  blkxfer_cmp #(.DW(DW)) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .key_in (acc_val),
    .rdata  (mem_rdata),
    .eq     (eq)
  );

  blkxfer_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_in    (cmd_in),
    .eq        (eq),
    .cnt_last  (cnt_last),
    .load      (load),
    .step_src  (step_src),
    .step_dst  (step_dst),
    .step_cnt  (step_cnt),
    .sel_dst   (sel_dst),
    .mem_we    (mem_we),
    .busy      (busy),
    .done      (done),
    .match     (match),
    .cnt_nz    (cnt_nz),
    .cmd_q     (cmd_q)
  );

  assign mem_addr  = sel_dst ? ptr_q[1] : ptr_q[0];
  assign mem_wdata = mem_rdata;
  assign src_ptr   = ptr_q[0];
  assign dst_ptr   = ptr_q[1];
  assign cnt_val   = cnt_q;

  // R5
  rpt_zero_end_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cmd_q.rpt && !match) |-> (cnt_val == '0));

  // R7
  match_search_only_chk: assert property (@(posedge clk) disable iff (rst)
    match |-> cmd_q.search);
endmodule

// File: tb/test_blkxfer_engine.sv
module test_blkxfer_engine;

  typedef struct packed {
    logic        s;
    logic        d;
    logic        r;
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] cnt;
    logic [7:0]  acc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0010, 16'h0100, 16'h0005, 8'h00}, // copy up single
    '{1'b0, 1'b0, 1'b1, 16'h0020, 16'h0200, 16'h0008, 8'h00}, // copy up repeat
    '{1'b0, 1'b1, 1'b1, 16'h0050, 16'h0300, 16'h0006, 8'h00}, // copy down repeat
    '{1'b0, 1'b1, 1'b0, 16'h0060, 16'h0310, 16'h0001, 8'h00}, // copy down single, count ends 0
    '{1'b1, 1'b0, 1'b1, 16'h0080, 16'h1234, 16'h0004, 8'hFF}, // search up, key absent
    '{1'b1, 1'b0, 1'b1, 16'h0080, 16'h1234, 16'h0010, 8'h98}, // search up, hits at 0x83
    '{1'b1, 1'b1, 1'b1, 16'h0002, 16'h0000, 16'h0006, 8'h01}, // search down across zero
    '{1'b1, 1'b0, 1'b0, 16'h0040, 16'h0000, 16'h0000, 8'h00}, // single with count 0
    '{1'b1, 1'b0, 1'b1, 16'h0040, 16'h0000, 16'h0000, 8'hE6}, // count 0 repeat, hits at 0x45
    '{1'b0, 1'b0, 1'b1, 16'h0140, 16'h0141, 16'h0004, 8'h00}, // overlapping copy
    '{1'b0, 1'b0, 1'b1, 16'hFFFE, 16'h01F0, 16'h0004, 8'h00}, // copy source wraps
    '{1'b1, 1'b1, 1'b0, 16'h0070, 16'h0000, 16'h0003, 8'h13}  // search down single
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_search = 1'b0, cmd_down = 1'b0, cmd_repeat = 1'b0;
  logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
  logic [7:0]  acc_val = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done, match, cnt_nz;
  logic [15:0] src_ptr, dst_ptr, cnt_val;

  logic        fill_en = 1'b0;
  logic [9:0]  fill_a = '0;
  logic [7:0]  fill_d = '0;
  logic [7:0]  ram     [0:1023];
  logic [7:0]  ref_mem [0:1023];

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (fill_en)     ram[fill_a] <= fill_d;
    else if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[9:0]];
  end

  blkxfer_engine i_blkxfer_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_search(cmd_search),
    .cmd_down(cmd_down), .cmd_repeat(cmd_repeat), .src_init(src_init),
    .dst_init(dst_init), .cnt_init(cnt_init), .acc_val(acc_val),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .match(match),
    .cnt_nz(cnt_nz), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .cnt_val(cnt_val)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic model(input vec_t v, output logic [15:0] es, output logic [15:0] ed,
                       output logic [15:0] ec, output logic em, output int nb);
    logic [15:0] s, d, c;
    logic eqv, stop;
    s = v.src; d = v.dst; c = v.cnt; nb = 0; eqv = 1'b0;
    do begin
      if (!v.s) ref_mem[d[9:0]] = ref_mem[s[9:0]];
      else      eqv = (ref_mem[s[9:0]] == v.acc);
      s = v.d ? s - 16'd1 : s + 16'd1;
      if (!v.s) d = v.d ? d - 16'd1 : d + 16'd1;
      c = c - 16'd1;
      nb++;
      stop = !v.r || (c == 16'd0) || (v.s && eqv);
    end while (!stop && nb < 70000);
    es = s; ed = d; ec = c; em = v.s && eqv;
  endtask

  task automatic drive(input vec_t v);
    cmd_search = v.s; cmd_down = v.d; cmd_repeat = v.r;
    src_init = v.src; dst_init = v.dst; cnt_init = v.cnt; acc_val = v.acc;
  endtask

  task automatic wait_done(output int cyc, output int wes);
    cyc = 1; wes = 0;
    while (!done && cyc < 4000) begin
      if (mem_we) wes++;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic check_result(input vec_t v, input int cyc, input int wes);
    logic [15:0] es, ed, ec;
    logic em;
    int nb, bad;
    string dtag;
    model(v, es, ed, ec, em, nb);
    dtag = v.d ? "R4 R12" : "R3 R12";
    chk(done === 1'b1, "R8 done seen", 32'(done), 32'd1);
    chk(cyc == 2 * nb + 1, "R8 R2 cycles to done", 32'(cyc), 32'(2 * nb + 1));
    chk(src_ptr === es, {dtag, " src pointer"}, 32'(src_ptr), 32'(es));
    chk(dst_ptr === ed, v.s ? "R6 dst untouched" : {dtag, " dst pointer"}, 32'(dst_ptr), 32'(ed));
    chk(cnt_val === ec, v.r ? "R5 R7 R9 final counter" : "R8 R9 final counter", 32'(cnt_val), 32'(ec));
    chk(match === em, "R7 match flag", 32'(match), 32'(em));
    chk(cnt_nz === (ec != 16'd0), "R10 cnt_nz flag", 32'(cnt_nz), 32'(ec != 16'd0));
    chk(wes == (v.s ? 0 : nb), v.s ? "R6 no writes" : "R2 one write per byte", 32'(wes), 32'(v.s ? 0 : nb));
    @(negedge clk);
    chk(done === 1'b0, "R8 done single pulse", 32'(done), 32'd0);
    bad = 0;
    for (int a = 0; a < 1024; a++) if (ram[a] !== ref_mem[a]) bad++;
    chk(bad == 0, "R2 memory image", 32'(bad), 32'd0);
  endtask

  initial begin
    int cyc, wes;
    logic [15:0] hs, hd, hc;
    logic hm, hn;
    vec_t va, vb;

    // Fill the memory under reset with pattern (7*a + 3).
    @(negedge clk);
    fill_en = 1'b1;
    for (int a = 0; a < 1024; a++) begin
      fill_a = 10'(a);
      fill_d = 8'(a * 7 + 3);
      ref_mem[a] = 8'(a * 7 + 3);
      @(negedge clk);
    end
    fill_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(busy === 1'b0,   "R1 busy after reset",   32'(busy),   32'd0);
    chk(done === 1'b0,   "R1 done after reset",   32'(done),   32'd0);
    chk(match === 1'b0,  "R1 match after reset",  32'(match),  32'd0);
    chk(cnt_nz === 1'b0, "R1 cnt_nz after reset", 32'(cnt_nz), 32'd0);
    chk(mem_we === 1'b0, "R1 mem_we after reset", 32'(mem_we), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done(cyc, wes);
      check_result(VECS[i], cyc, wes);
    end

    // R10 results hold while idle
    hs = src_ptr; hd = dst_ptr; hc = cnt_val; hm = match; hn = cnt_nz;
    repeat (5) @(negedge clk);
    chk({src_ptr, dst_ptr, cnt_val, match, cnt_nz} === {hs, hd, hc, hm, hn},
        "R10 outputs held while idle", 32'({match, cnt_nz}), 32'({hm, hn}));

    // R11 commands while busy are ignored
    va = '{1'b0, 1'b0, 1'b1, 16'h0030, 16'h0380, 16'h0003, 8'h00};
    vb = '{1'b1, 1'b1, 1'b0, 16'h0099, 16'h0000, 16'h0001, 8'h55};
    drive(va);
    cmd_valid = 1'b1;
    @(negedge clk);
    drive(vb);
    cyc = 1; wes = 0;
    while (!done && cyc < 4000) begin
      if (mem_we) wes++;
      @(negedge clk);
      cyc++;
      if (cyc > 3) cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    chk(src_ptr === 16'h0033, "R11 busy command ignored", 32'(src_ptr), 32'h33);
    check_result(va, cyc, wes);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule